// File: doc/BRIEF.md
# Branch Target Buffer with Full-PC Tag Match

This block is a direct-mapped table that the instruction fetch stage consults every cycle. The fetch stage presents the PC of the instruction it is fetching. In the same cycle the block reports whether a branch is recorded for exactly that PC, and which PC fetch should use next. The next PC is the stored target when the entry's direction counter favours taken. Otherwise it is the sequential address, PC plus 4.

When a branch resolves later in the pipeline, the resolve port reports its PC, its outcome and its target. A resolving branch that already owns its entry moves the entry's 2-bit saturating counter one step toward the outcome, and the reported target replaces the stored one. A taken branch that is not in the table takes over the entry at its index, displacing whatever was there, and starts with a weakly-taken counter. A not-taken branch that is not in the table leaves the table unchanged.

Top module: `brtgt_buffer`

## Requirements
- R1: Synchronous reset invalidates every entry, so after reset every lookup reports no hit until a resolve installs something.
- R2: When the lookup finds no matching entry, `fetch_hit` is 0 and `next_pc` equals `fetch_pc + 4`, in the same cycle.
- R3: An entry is selected by index bits `pc[IDX_W+1:2]` (IDX_W = log2 DEPTH; bits [7:2] at the default depth of 64). A hit additionally requires all remaining PC bits to equal the stored ones, so a PC that differs only above the index (for example, one 0x100 away at the default depth) misses.
- R4: On a hit whose counter is 2 or 3 (bit 1 set), `fetch_hit` is 1 and `next_pc` is the stored target, in the same cycle as `fetch_pc`.
- R5: On a hit whose counter is 0 or 1, `fetch_hit` is 1 and `next_pc` is `fetch_pc + 4`.
- R6: A taken resolve that misses allocates the entry with counter 2 (binary 10, weakly taken). The entry is visible to lookups from the next cycle on, so a single later not-taken resolve stops it redirecting.
- R7: A not-taken resolve that misses writes nothing, so a later lookup of that PC still misses.
- R8: A resolve that hits increments the counter on taken and decrements it on not-taken, saturating at 3 and at 0.
- R9: A resolve that hits replaces the stored target with the resolve target.
- R10: An allocation overwrites the previous occupant of the index, so the old PC then misses while other indices keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| next_pc | output | PC_W | Predicted next fetch PC (combinational) |
| fetch_hit | output | 1 | Full-PC match on a valid entry |
| upd_valid | input | 1 | A branch resolves this cycle |
| upd_pc | input | PC_W | PC of the resolving branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | PC_W | Resolved taken-target address |

## Verification
The assertions check the following on every cycle:
- the sequential next PC on every miss;
- that no entry survives reset;
- that a taken resolve makes its PC hit on the very next cycle;
- that two back-to-back taken resolves of one PC make it redirect to the latest target.

Several behaviours appear only in the bench's directed sequences, which watch redirect decisions at the fetch port:
- the exact counter trajectory, including saturation at both ends;
- the weakly-taken starting value;
- the refusal to allocate on a not-taken miss;
- aliasing between PCs that share an index;
- displacement of an old occupant.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    typedef logic [1:0] sat2_t;

    localparam sat2_t SAT_WEAK_TAKEN = 2'b10;
    localparam int    INSTR_BYTES    = 4;
    localparam int    OFF_W          = $clog2(INSTR_BYTES);

    typedef enum logic [1:0] {
        WR_NONE    = 2'd0,
        WR_ALLOC   = 2'd1,
        WR_REFRESH = 2'd2
    } wr_kind_e;

    // move a saturating counter one step toward the outcome
    function automatic sat2_t sat2_step(sat2_t c, logic taken);
        if (taken)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    function automatic logic sat2_predicts_taken(sat2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/brtgt_store.sv
module brtgt_store
    import brtgt_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 64,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic             rd_a_valid,
    output logic [TAG_W-1:0] rd_a_tag,
    output logic [PC_W-1:0]  rd_a_target,
    output sat2_t            rd_a_ctr,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic             rd_b_valid,
    output logic [TAG_W-1:0] rd_b_tag,
    output sat2_t            rd_b_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target,
    input  sat2_t            wr_ctr
);

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [PC_W-1:0]  tgt_mem [DEPTH];
    sat2_t            ctr_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            tgt_mem[wr_idx] <= wr_target;
            ctr_mem[wr_idx] <= wr_ctr;
        end
    end

    always_comb begin
        rd_a_valid  = vld_q[rd_a_idx];
        rd_a_tag    = tag_mem[rd_a_idx];
        rd_a_target = tgt_mem[rd_a_idx];
        rd_a_ctr    = ctr_mem[rd_a_idx];
        rd_b_valid  = vld_q[rd_b_idx];
        rd_b_tag    = tag_mem[rd_b_idx];
        rd_b_ctr    = ctr_mem[rd_b_idx];
    end

endmodule

// File: rtl/brtgt_lookup.sv
module brtgt_lookup
    import brtgt_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TAG_W-1:0] pc_tag,
    input  logic             e_valid,
    input  logic [TAG_W-1:0] e_tag,
    input  logic [PC_W-1:0]  e_target,
    input  sat2_t            e_ctr,
    output logic             hit,
    output logic [PC_W-1:0]  next_pc
);

    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_pc  = pc + PC_W'(INSTR_BYTES);
        hit     = e_valid && (e_tag == pc_tag);
        next_pc = (hit && sat2_predicts_taken(e_ctr)) ? e_target : seq_pc;
    end

endmodule

// File: rtl/brtgt_update.sv
module brtgt_update
    import brtgt_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             upd_valid,
    input  logic             upd_taken,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             e_valid,
    input  logic [TAG_W-1:0] e_tag,
    input  sat2_t            e_ctr,
    output logic             wr_en,
    output sat2_t            wr_ctr
);

    wr_kind_e kind;
    logic     owns;

    always_comb begin
        owns = e_valid && (e_tag == upd_tag);
        if (!upd_valid)
            kind = WR_NONE;
        else if (owns)
            kind = WR_REFRESH;
        else if (upd_taken)
            kind = WR_ALLOC;
        else
            kind = WR_NONE;

        wr_en = (kind != WR_NONE);
        unique case (kind)
            WR_REFRESH: wr_ctr = sat2_step(e_ctr, upd_taken);
            WR_ALLOC:   wr_ctr = SAT_WEAK_TAKEN;
            default:    wr_ctr = e_ctr;
        endcase
    end

endmodule

// File: rtl/brtgt_buffer.sv
module brtgt_buffer
    import brtgt_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            fetch_hit,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int IDX_L = OFF_W;
    localparam int IDX_H = OFF_W + IDX_W - 1;
    localparam int TAG_W = PC_W - IDX_W;   // every PC bit outside the index

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;

    assign f_idx = fetch_pc[IDX_H:IDX_L];
    assign u_idx = upd_pc[IDX_H:IDX_L];
    assign f_tag = {fetch_pc[PC_W-1:IDX_H+1], fetch_pc[IDX_L-1:0]};
    assign u_tag = {upd_pc[PC_W-1:IDX_H+1], upd_pc[IDX_L-1:0]};

    logic             a_valid, b_valid;
    logic [TAG_W-1:0] a_tag, b_tag;
    logic [PC_W-1:0]  a_target;
    sat2_t            a_ctr, b_ctr;
    logic             wr_en;
    sat2_t            wr_ctr;

    brtgt_store #(.PC_W(PC_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_a_idx   (f_idx),
        .rd_a_valid (a_valid),
        .rd_a_tag   (a_tag),
        .rd_a_target(a_target),
        .rd_a_ctr   (a_ctr),
        .rd_b_idx   (u_idx),
        .rd_b_valid (b_valid),
        .rd_b_tag   (b_tag),
        .rd_b_ctr   (b_ctr),
        .wr_en      (wr_en),
        .wr_idx     (u_idx),
        .wr_tag     (u_tag),
        .wr_target  (upd_target),
        .wr_ctr     (wr_ctr)
    );

    brtgt_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_lookup (
        .pc      (fetch_pc),
        .pc_tag  (f_tag),
        .e_valid (a_valid),
        .e_tag   (a_tag),
        .e_target(a_target),
        .e_ctr   (a_ctr),
        .hit     (fetch_hit),
        .next_pc (next_pc)
    );

    brtgt_update #(.TAG_W(TAG_W)) u_update (
        .upd_valid(upd_valid),
        .upd_taken(upd_taken),
        .upd_tag  (u_tag),
        .e_valid  (b_valid),
        .e_tag    (b_tag),
        .e_ctr    (b_ctr),
        .wr_en    (wr_en),
        .wr_ctr   (wr_ctr)
    );

endmodule

// File: rtl/brtgt_chk.sv
module brtgt_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic [PC_W-1:0] next_pc,
    input logic            fetch_hit,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !fetch_hit);

    // R2
    miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_hit |-> next_pc == fetch_pc + PC_W'(4));

    // R6
    taken_installs_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(upd_valid) && $past(upd_taken) && fetch_pc == $past(upd_pc))
        |-> fetch_hit);

    // R8
    twice_taken_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)
         && $past(upd_valid) && $past(upd_taken)
         && $past(upd_valid, 2) && $past(upd_taken, 2)
         && $past(upd_pc) == $past(upd_pc, 2) && fetch_pc == $past(upd_pc))
        |-> (fetch_hit && next_pc == $past(upd_target)));

endmodule

bind brtgt_buffer brtgt_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fetch_pc  (fetch_pc),
    .next_pc   (next_pc),
    .fetch_hit (fetch_hit),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken),
    .upd_target(upd_target)
);

// File: tb/brtgt_buffer_test.sv
module brtgt_buffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc   = '0;
    logic [PC_W-1:0] next_pc;
    logic            fetch_hit;
    logic            upd_valid  = 1'b0;
    logic [PC_W-1:0] upd_pc     = '0;
    logic            upd_taken  = 1'b0;
    logic [PC_W-1:0] upd_target = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic            hit;
        logic [PC_W-1:0] nxt;
        string           req;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    brtgt_buffer #(.PC_W(PC_W), .DEPTH(64)) uut (
        .clk       (clk),
        .rst       (rst),
        .fetch_pc  (fetch_pc),
        .next_pc   (next_pc),
        .fetch_hit (fetch_hit),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken),
        .upd_target(upd_target)
    );

    // driver: present a fetch PC and queue the expected response
    task automatic look(input logic [PC_W-1:0] pc, input logic hit,
                        input logic [PC_W-1:0] nxt, input string req);
        exp_t e;
        @(posedge clk); #1;
        upd_valid = 1'b0;
        fetch_pc  = pc;
        e.pc = pc; e.hit = hit; e.nxt = nxt; e.req = req;
        sb.push_back(e);
    endtask

    // driver: one resolve, committed at the following edge
    task automatic resolve(input logic [PC_W-1:0] pc, input logic taken,
                           input logic [PC_W-1:0] tgt);
        @(posedge clk); #1;
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = taken;
        upd_target = tgt;
        fetch_pc   = 32'h0000_0F00;
    endtask

    // monitor: compare at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (fetch_hit !== e.hit || next_pc !== e.nxt) begin
                errors++;
                $display("FAIL %s pc=%h actual hit=%b next=%h expected hit=%b next=%h",
                         e.req, e.pc, fetch_hit, next_pc, e.hit, e.nxt);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset
        look(32'h0000_1000, 1'b0, 32'h0000_1004, "R1");
        // R2: plain misses
        look(32'h0000_2000, 1'b0, 32'h0000_2004, "R2");
        look(32'h0000_20FC, 1'b0, 32'h0000_2100, "R2");

        // R7: not-taken miss does not allocate
        resolve(32'h0000_1010, 1'b0, 32'h0000_5000);
        look(32'h0000_1010, 1'b0, 32'h0000_1014, "R7");

        // R6/R4: taken miss allocates weakly taken, redirects
        resolve(32'h0000_1010, 1'b1, 32'h0000_5000);
        look(32'h0000_1010, 1'b1, 32'h0000_5000, "R4");
        // R3: same index, different upper bits
        look(32'h0000_1110, 1'b0, 32'h0000_1114, "R3");
        // R3: same index, different low offset bits
        look(32'h0000_1012, 1'b0, 32'h0000_1016, "R3");

        // R6/R5: one not-taken from 10 -> 01, hit without redirect
        resolve(32'h0000_1010, 1'b0, 32'h0000_5000);
        look(32'h0000_1010, 1'b1, 32'h0000_1014, "R5");

        // R8: saturate low, then climb
        resolve(32'h0000_1010, 1'b0, 32'h0000_5000);   // 00
        resolve(32'h0000_1010, 1'b0, 32'h0000_5000);   // 00
        resolve(32'h0000_1010, 1'b1, 32'h0000_5000);   // 01
        look(32'h0000_1010, 1'b1, 32'h0000_1014, "R8");
        resolve(32'h0000_1010, 1'b1, 32'h0000_5000);   // 10
        look(32'h0000_1010, 1'b1, 32'h0000_5000, "R8");

        // R8: saturate high, then descend
        resolve(32'h0000_1010, 1'b1, 32'h0000_5000);   // 11
        resolve(32'h0000_1010, 1'b1, 32'h0000_5000);   // 11
        resolve(32'h0000_1010, 1'b0, 32'h0000_5000);   // 10
        look(32'h0000_1010, 1'b1, 32'h0000_5000, "R8");
        resolve(32'h0000_1010, 1'b0, 32'h0000_5000);   // 01
        look(32'h0000_1010, 1'b1, 32'h0000_1014, "R8");

        // R9: refresh replaces the target
        resolve(32'h0000_1010, 1'b1, 32'h0000_6000);   // 10
        look(32'h0000_1010, 1'b1, 32'h0000_6000, "R9");

        // R10: alias allocation evicts the old occupant
        resolve(32'h0000_20FC, 1'b1, 32'h0000_3000);   // index 63
        resolve(32'h0000_1110, 1'b1, 32'h0000_7000);
        look(32'h0000_1110, 1'b1, 32'h0000_7000, "R10");
        look(32'h0000_1010, 1'b0, 32'h0000_1014, "R10");
        look(32'h0000_20FC, 1'b1, 32'h0000_3000, "R10");

        // R1: reset again clears installed entries
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        look(32'h0000_1110, 1'b0, 32'h0000_1114, "R1");
        look(32'h0000_20FC, 1'b0, 32'h0000_2100, "R1");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule